// File: doc/BRIEF.md
# Seconds Counter with Interval Interrupt

This block keeps time as a free-running binary count of seconds. A one-cycle `tick_1hz` pulse advances a 32-bit counter while the oscillator enable in the control byte is set. The counter wraps to zero after its largest value. The same control byte arms a periodic interrupt. Its interval is a power of two, taken from one counter bit. Each interrupt is an active-low pulse on `int_n` that lasts a fixed number of `tick_us` microsecond pulses.

A bit-level link layer sits in front of the block and hands it whole bytes. A bus reset is a one-cycle `bus_reset` pulse. The first byte after a bus reset is a function command. Read clock (66h) takes a snapshot of the counter into a buffer. It then presents the control byte, followed by the counter bytes from least to most significant. The sequence repeats after the fifth byte. Write clock (99h) takes a control byte, which applies at once, and then four counter bytes into the buffer. The buffer is copied into the counter at the next bus reset.

Top module: `interval_timekeeper`

## Requirements
- R1: After `rst_n` is released, `int_n` is 1 and `rd_byte` is FFh. A read clock then returns a control byte of 00h and a count of 0, so the oscillator is off, interrupts are disabled and the interval code is 0.
- R2: The counter holds its value while the oscillator is off. While it is on, each `tick_1hz` adds 1, and FFFFFFFFh plus one tick gives 0.
- R3: A control byte write applies from the next cycle: bit 7 is interrupt enable, bits 6:4 are the interval code, and bit 3 is oscillator enable (bit 2 is ignored on write). The control byte reads as {enable, code, osc, osc, 2'b00}, so bits 1:0 always read 0 and bits 3 and 2 both report the oscillator.
- R4: Command 66h copies the counter into the buffer in the cycle it is accepted. From the next cycle `rd_byte` shows the control byte, and each `rd_req` steps to count byte 0 (bits 7:0) up to byte 3 (bits 31:24). The sequence then returns to the control byte. Ticks during the read do not change the bytes shown.
- R5: Command 99h takes the first `wr_valid` byte as the control byte and the next four as count bytes, least significant first. Later bytes are ignored. The counter is loaded from the buffer at the next `bus_reset` only if all four count bytes arrived; otherwise the counter is left alone.
- R6: Only the first byte after a bus reset is taken as a command. Any code other than 66h or 99h makes the block ignore commands, writes and read requests until the next `bus_reset`.
- R7: With interrupts enabled, a 0-to-1 change of the selected counter bit starts a low pulse on `int_n` in the following cycle. The interval codes 0 to 7 select bits 0, 2, 5, 6, 11, 12, 16 and 17. The pulse stays low for 122 `tick_us` pulses.
- R8: With interrupts disabled, no pulse is produced. Switching to an interval code whose counter bit is already 1 (while the previous code's bit was 0) produces a pulse immediately.
- R9: `rd_byte` is FFh whenever no read clock sequence is active, including the cycle after any `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| bus_reset | input | 1 | One-cycle pulse: bus reset seen by the link layer |
| cmd_valid | input | 1 | Function command byte present |
| cmd_byte | input | 8 | Function command code |
| wr_valid | input | 1 | Data byte written by the bus master |
| wr_byte | input | 8 | Written data byte |
| rd_req | input | 1 | Current read byte consumed; advance to the next |
| rd_byte | output | 8 | Byte offered to the bus master, FFh when idle |
| int_n | output | 1 | Active-low interrupt pulse (open-drain level) |

## Verification
The assertions assume that the strobes `bus_reset`, `cmd_valid`, `wr_valid` and `rd_req` are single-cycle pulses that never coincide. They also assume that `tick_us` arrives often enough that a low pulse always ends. The bench drives each byte event as one isolated pulse between two falling clock edges, so no two strobes overlap. A free-running divider produces `tick_us` every fourth cycle, and the bench waits for `int_n` to return high before it arms the next interval test.

// File: rtl/tk_pkg.sv
// Shared types and helpers for the interval timekeeper.
// Assumes the counter is at least 18 bits wide and a whole number of bytes.
package tk_pkg;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_MUTE  = 2'd3
    } tk_state_e;

    localparam logic [7:0] CMD_READ_CLOCK  = 8'h66;
    localparam logic [7:0] CMD_WRITE_CLOCK = 8'h99;
    localparam int         NUM_INTERVALS   = 8;

    typedef struct packed {
        logic       irq_en;
        logic [2:0] sel;
        logic       osc_on;
    } tk_ctrl_t;

    // Counter bit whose rising edge marks one interval of the given code.
    function automatic int tap_bit(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 5;
            3:       return 6;
            4:       return 11;
            5:       return 12;
            6:       return 16;
            default: return 17;
        endcase
    endfunction

    // Control state as seen by a reader: oscillator reported twice, low bits zero.
    function automatic logic [7:0] ctrl_to_byte(input tk_ctrl_t c);
        return {c.irq_en, c.sel, c.osc_on, c.osc_on, 2'b00};
    endfunction

    // Written byte to control state: bit 3 alone decides the oscillator.
    function automatic tk_ctrl_t byte_to_ctrl(input logic [7:0] b);
        tk_ctrl_t c;
        c.irq_en = b[7];
        c.sel    = b[6:4];
        c.osc_on = b[3];
        return c;
    endfunction

endpackage

// File: rtl/tk_seconds.sv
// Binary seconds counter.
// Counts one per tick while running, wraps at full scale, and takes a
// parallel load that has priority over a tick in the same cycle.
module tk_seconds #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    // Load, count or hold the seconds value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && tick_sec) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tk_interrupt.sv
// Interval interrupt generator.
// Watches the counter bit picked by the interval code and, when enabled,
// starts a low pulse of PULSE_US microsecond ticks on each 0-to-1 change.
// Assumes tick_us is a single-cycle pulse.
module tk_interrupt #(
    parameter int CNT_W    = 32,
    parameter int PULSE_US = 122
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [2:0]       sel,
    input  logic             irq_en,
    input  logic             tick_us,
    output logic             int_n
);
    import tk_pkg::*;

    localparam int PW_W = $clog2(PULSE_US + 1);

    logic [NUM_INTERVALS-1:0] taps;
    logic                     sel_now;
    logic                     prev_q;
    logic                     trig;
    logic [PW_W-1:0]          remain_q;

    for (genvar g = 0; g < NUM_INTERVALS; g++) begin : g_tap
        assign taps[g] = count[tap_bit(g)];
    end

    assign sel_now = taps[sel];
    assign trig    = sel_now && !prev_q && irq_en;
    assign int_n   = (remain_q == '0);

    // Remember the selected bit to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sel_now;
        end
    end

    // Load the pulse width on a trigger, else count it down per microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (trig) begin
            remain_q <= PW_W'(PULSE_US);
        end else if (tick_us && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/tk_cmd.sv
// Clock function command engine.
// Decodes the first byte after a bus reset, snapshots the counter for reads,
// gathers written bytes into the shared buffer, applies the control byte and
// requests a counter load at the bus reset that closes a complete write.
// Assumes the byte strobes are single-cycle and mutually exclusive.
module tk_cmd #(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              rd_req,
    input  logic [CNT_W-1:0]  count,
    output tk_pkg::tk_ctrl_t  ctrl,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [7:0]        rd_byte,
    output tk_pkg::tk_state_e state
);
    import tk_pkg::*;

    localparam int NBYTES = CNT_W / 8;
    localparam int IDX_W  = $clog2(NBYTES + 2);
    localparam int WR_DONE = NBYTES + 1;

    logic [NBYTES-1:0][7:0] sbuf_q;
    logic [IDX_W-1:0]       idx_q;

    assign load     = bus_reset && state == ST_WRITE && int'(idx_q) == WR_DONE;
    assign load_val = sbuf_q;

    // Sequence state, byte index and the shared read/write buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_CMD;
            idx_q  <= '0;
            sbuf_q <= '0;
        end else if (bus_reset) begin
            state <= ST_CMD;
            idx_q <= '0;
        end else begin
            case (state)
                ST_CMD: begin
                    if (cmd_valid) begin
                        idx_q <= '0;
                        if (cmd_byte == CMD_READ_CLOCK) begin
                            state  <= ST_READ;
                            sbuf_q <= count;
                        end else if (cmd_byte == CMD_WRITE_CLOCK) begin
                            state <= ST_WRITE;
                        end else begin
                            state <= ST_MUTE;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_req) begin
                        idx_q <= (int'(idx_q) == NBYTES) ? '0 : idx_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (wr_valid && int'(idx_q) < WR_DONE) begin
                        for (int b = 0; b < NBYTES; b++) begin
                            if (int'(idx_q) == b + 1) sbuf_q[b] <= wr_byte;
                        end
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Control byte takes effect as soon as the first write byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (!bus_reset && state == ST_WRITE && wr_valid && idx_q == '0) begin
            ctrl <= byte_to_ctrl(wr_byte);
        end
    end

    // Byte offered to the reader: control byte first, then buffer bytes.
    always_comb begin
        rd_byte = 8'hFF;
        if (state == ST_READ) begin
            if (idx_q == '0) begin
                rd_byte = ctrl_to_byte(ctrl);
            end else begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (int'(idx_q) == b + 1) rd_byte = sbuf_q[b];
                end
            end
        end
    end

endmodule

// File: rtl/interval_timekeeper.sv
// Seconds counter with interval interrupt, top level.
// Joins the command engine, the seconds counter and the interrupt generator.
// Assumes a byte-level link layer in front and free-running 1 Hz and 1 us ticks.
module interval_timekeeper #(
    parameter int CNT_W    = 32,
    parameter int PULSE_US = 122
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       tick_us,
    input  logic       bus_reset,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic [7:0] rd_byte,
    output logic       int_n
);
    import tk_pkg::*;

    tk_ctrl_t         ctrl;
    tk_state_e        cmd_state;
    logic             load_now;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] seconds;

    tk_cmd #(.CNT_W(CNT_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_reset(bus_reset),
        .cmd_valid(cmd_valid),
        .cmd_byte (cmd_byte),
        .wr_valid (wr_valid),
        .wr_byte  (wr_byte),
        .rd_req   (rd_req),
        .count    (seconds),
        .ctrl     (ctrl),
        .load     (load_now),
        .load_val (load_val),
        .rd_byte  (rd_byte),
        .state    (cmd_state)
    );

    tk_seconds #(.CNT_W(CNT_W)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_sec(tick_1hz),
        .run     (ctrl.osc_on),
        .load    (load_now),
        .load_val(load_val),
        .count   (seconds)
    );

    tk_interrupt #(.CNT_W(CNT_W), .PULSE_US(PULSE_US)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (seconds),
        .sel    (ctrl.sel),
        .irq_en (ctrl.irq_en),
        .tick_us(tick_us),
        .int_n  (int_n)
    );

endmodule

// File: rtl/tk_checker.sv
// Property checker for the interval timekeeper, bound to the top level.
// Assumes single-cycle, non-overlapping byte strobes.
module tk_checker #(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              tick_us,
    input logic              bus_reset,
    input logic              rd_req,
    input logic [7:0]        rd_byte,
    input logic              int_n,
    input logic [CNT_W-1:0]  seconds,
    input logic              osc_on,
    input logic              irq_en,
    input logic              load_now,
    input tk_pkg::tk_state_e cmd_state
);
    import tk_pkg::*;

    // R2: a stopped counter without a load keeps its value
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_on && !load_now) |=> $stable(seconds));

    // R2: a running counter steps by one per tick, wrapping at full scale
    a_r2_step_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_on && tick_1hz && !load_now) |=> (seconds == $past(seconds) + 1'b1));

    // R4: read bytes stay fixed between requests, whatever the ticks do
    a_r4_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_state == ST_READ && !rd_req && !bus_reset) |=> $stable(rd_byte));

    // R7: a low pulse only shortens on a microsecond tick
    a_r7_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !tick_us) |=> !int_n);

    // R8: a pulse only starts while interrupts are enabled
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(irq_en));

    // R9: the read output is released after every bus reset
    a_r9_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (rd_byte == 8'hFF));

endmodule

bind interval_timekeeper tk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .tick_us  (tick_us),
    .bus_reset(bus_reset),
    .rd_req   (rd_req),
    .rd_byte  (rd_byte),
    .int_n    (int_n),
    .seconds  (seconds),
    .osc_on   (ctrl.osc_on),
    .irq_en   (ctrl.irq_en),
    .load_now (load_now),
    .cmd_state(cmd_state)
);

// File: tb/interval_timekeeper_test.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module interval_timekeeper_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       tick_us = 1'b0;
    logic       bus_reset = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd_byte;
    logic       int_n;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    us_div = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    interval_timekeeper uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_us(tick_us),
        .bus_reset(bus_reset), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .rd_byte(rd_byte), .int_n(int_n)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_cnt;
    logic [7:0]  m_buf [4];
    int          m_state;   // 0 command, 1 read, 2 write, 3 ignore
    int          m_idx;
    bit          m_osc, m_ie, m_prev;
    int          m_sel;
    int          m_remain;

    function automatic int tapb(input int s);
        int t[8] = '{0, 2, 5, 6, 11, 12, 16, 17};
        return t[s];
    endfunction

    function automatic logic [7:0] m_ctrl();
        return {m_ie, 3'(m_sel), m_osc, m_osc, 2'b00};
    endfunction

    function automatic logic [7:0] m_rd();
        if (m_state != 1) return 8'hFF;
        if (m_idx == 0) return m_ctrl();
        return m_buf[m_idx - 1];
    endfunction

    always @(posedge clk) begin
        logic [31:0] old_cnt;
        bit old_osc, sel_bit, do_load;
        if (!rst_n) begin
            m_cnt = 0; m_state = 0; m_idx = 0; m_osc = 0; m_ie = 0;
            m_sel = 0; m_prev = 0; m_remain = 0;
            foreach (m_buf[i]) m_buf[i] = 8'h00;
        end else begin
            old_cnt = m_cnt;
            old_osc = m_osc;
            sel_bit = old_cnt[tapb(m_sel)];
            if (sel_bit && !m_prev && m_ie) m_remain = 122;
            else if (tick_us && m_remain > 0) m_remain = m_remain - 1;
            m_prev = sel_bit;
            do_load = bus_reset && m_state == 2 && m_idx == 5;
            if (bus_reset) begin
                m_state = 0; m_idx = 0;
            end else if (m_state == 0 && cmd_valid) begin
                m_idx = 0;
                if (cmd_byte == 8'h66) begin
                    m_state = 1;
                    for (int i = 0; i < 4; i++) m_buf[i] = old_cnt[8*i +: 8];
                end else if (cmd_byte == 8'h99) m_state = 2;
                else m_state = 3;
            end else if (m_state == 1 && rd_req) begin
                m_idx = (m_idx + 1) % 5;
            end else if (m_state == 2 && wr_valid && m_idx < 5) begin
                if (m_idx == 0) begin
                    m_ie = wr_byte[7]; m_sel = int'(wr_byte[6:4]); m_osc = wr_byte[3];
                end else m_buf[m_idx - 1] = wr_byte;
                m_idx = m_idx + 1;
            end
            if (do_load) m_cnt = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
            else if (tick_1hz && old_osc) m_cnt = old_cnt + 1;
        end
    end

    // Microsecond tick: every fourth cycle.
    always @(negedge clk) begin
        us_div = (us_div + 1) % 4;
        tick_us = (us_div == 0);
    end

    // Compare outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_byte !== m_rd() || int_n !== (m_remain == 0)) begin
                errors++;
                $display("FAIL %s per-cycle: rd_byte=%h int_n=%b expected rd_byte=%h int_n=%b",
                         tag, rd_byte, int_n, m_rd(), (m_remain == 0));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk) begin cmd_valid = 1'b1; cmd_byte = b; end
        @(negedge clk) cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) begin wr_valid = 1'b1; wr_byte = b; end
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic tick_sec();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
    endtask

    task automatic read_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(rd_byte == exp, req, "read byte", 32'(rd_byte), 32'(exp));
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
    endtask

    task automatic read_all(input logic [7:0] ec, input logic [31:0] ev, input string req);
        pulse_reset();
        send_cmd(8'h66);
        read_expect(ec, req);
        for (int i = 0; i < 4; i++) read_expect(ev[8*i +: 8], req);
        pulse_reset();
    endtask

    task automatic set_time(input logic [7:0] c, input logic [31:0] v);
        pulse_reset();
        send_cmd(8'h99);
        send_byte(c);
        for (int i = 0; i < 4; i++) send_byte(v[8*i +: 8]);
        pulse_reset();
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (int_n !== 1'b1) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk(int_n == 1'b1, "R1", "int_n after reset", 32'(int_n), 32'd1);
        chk(rd_byte == 8'hFF, "R1", "rd_byte after reset", 32'(rd_byte), 32'hFF);
        read_all(8'h00, 32'h0, "R1");

        tag = "R2";
        repeat (3) tick_sec();
        read_all(8'h00, 32'h0, "R2");

        tag = "R5";
        set_time(8'h08, 32'h12345678);
        read_all(8'h0C, 32'h12345678, "R5");

        tag = "R4";
        repeat (3) tick_sec();
        pulse_reset();
        send_cmd(8'h66);
        read_expect(8'h0C, "R4");
        repeat (2) tick_sec();
        read_expect(8'h7B, "R4");
        read_expect(8'h56, "R4");
        read_expect(8'h34, "R4");
        read_expect(8'h12, "R4");
        read_expect(8'h0C, "R4");
        read_expect(8'h7B, "R4");
        pulse_reset();

        tag = "R5";
        pulse_reset();
        send_cmd(8'h99);
        send_byte(8'h04);
        send_byte(8'hAA);
        pulse_reset();
        read_all(8'h00, 32'h1234567D, "R5");
        tag = "R2";
        tick_sec();
        read_all(8'h00, 32'h1234567D, "R2");

        tag = "R3";
        pulse_reset();
        send_cmd(8'h99);
        send_byte(8'h0B);
        pulse_reset();
        read_all(8'h0C, 32'h1234567D, "R3");

        tag = "R5";
        pulse_reset();
        send_cmd(8'h99);
        send_byte(8'h08);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        send_byte(8'h55);
        pulse_reset();
        read_all(8'h0C, 32'h44332211, "R5");

        tag = "R6";
        pulse_reset();
        send_cmd(8'h5A);
        send_byte(8'hF0);
        send_cmd(8'h66);
        @(negedge clk);
        chk(rd_byte == 8'hFF, "R6", "rd_byte after unknown command", 32'(rd_byte), 32'hFF);
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        chk(rd_byte == 8'hFF, "R9", "rd_byte with no read active", 32'(rd_byte), 32'hFF);
        read_all(8'h0C, 32'h44332211, "R6");

        tag = "R2";
        set_time(8'h08, 32'hFFFFFFFF);
        tick_sec();
        read_all(8'h0C, 32'h00000000, "R2");

        tag = "R7";
        for (int k = 0; k < 8; k++) begin
            int low_cycles;
            set_time(8'h8C | 8'(k << 4), (32'd1 << tapb(k)) - 32'd1);
            wait_idle();
            chk(int_n == 1'b1, "R7", "int_n before edge", 32'(int_n), 32'd1);
            tick_sec();
            chk(int_n == 1'b1, "R7", "int_n in edge cycle", 32'(int_n), 32'd1);
            @(negedge clk);
            chk(int_n == 1'b0, "R7", "int_n after selected bit rose", 32'(int_n), 32'd0);
            low_cycles = 1;
            while (int_n == 1'b0) begin
                @(negedge clk);
                low_cycles++;
            end
            chk(low_cycles >= 484 && low_cycles <= 492, "R7", "pulse length in cycles",
                32'(low_cycles), 32'd488);
        end

        tag = "R8";
        set_time(8'h0C, 32'h0);
        wait_idle();
        tick_sec();
        repeat (8) @(negedge clk);
        chk(int_n == 1'b1, "R8", "int_n with interrupts disabled", 32'(int_n), 32'd1);

        set_time(8'h8C, 32'h20);
        wait_idle();
        pulse_reset();
        send_cmd(8'h99);
        send_byte(8'hAC);
        @(negedge clk);
        chk(int_n == 1'b0, "R8", "immediate pulse on code change", 32'(int_n), 32'd0);
        pulse_reset();
        wait_idle();
        read_all(8'hAC, 32'h20, "R8");

        tag = "R9";
        @(negedge clk);
        chk(rd_byte == 8'hFF, "R9", "rd_byte after bus reset", 32'(rd_byte), 32'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule